// File: doc/BRIEF.md
# Paged Virtual-to-Physical Address Translator

This block converts a virtual word address into a physical one. The upper bits of the address are the page number, and the block swaps them for a frame number. The lower bits are the offset within the page, and they pass through unchanged. A small fully associative translation buffer is looked up first. If it holds the page, the answer arrives on the next cycle. If it does not, the block reads its own page table, which has one entry for each virtual page. A page that is present is then copied into the buffer, replacing buffer entries in a round-robin order. A page that is absent produces a fault response, and no physical address is given.

Software controls the page table through a load port. Each write sets an entry's frame number, its present flag and its modified flag. The same port can clear any of these. A combinational read port returns the entry for any page, so the modified status can be read back. When a translated access is a write, the page is marked modified. This tells the replacement logic that the page must be saved before its frame is reused. When software rewrites an entry, any buffer copy of that page is dropped, so an old translation is never returned.

Top module: `vmem_xlate`

## Requirements
- R1: After reset, `rsp_valid` is low, `req_ready` is high, and every page-table entry reads back with present = 0 and modified = 0.
- R2: A successful translation returns `rsp_pa` with the entry's frame number in the upper bits (bits PA_W-1 down to OFF_W). The lower OFF_W bits are equal to the same bits of the request address.
- R3: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. If the buffer holds the page, the response appears in the following cycle with `rsp_tlb_hit` = 1.
- R4: If the buffer does not hold the page, `req_ready` is low in the cycle after acceptance. The response then appears two cycles after acceptance with `rsp_tlb_hit` = 0. If the page is present, it is loaded into the buffer, and the next access to it is a hit.
- R5: If the page is not present, the response has `rsp_fault` = 1, `rsp_pa` = 0 and `rsp_tlb_hit` = 0. The buffer is not loaded, so a repeat access misses again.
- R6: A successful access with `req_wr` = 1 sets the page's modified flag. Reads do not set it, and neither do faulting writes.
- R7: A pulse on `sw_we` loads the frame, present and modified fields of page `sw_page`. The read port then returns those fields for `sw_rd_page` in the same cycle.
- R8: A software write to a page removes that page from the buffer. The next access to the page misses and returns the new entry. At most one buffer entry ever matches a page.
- R9: The buffer has TLB_N entries, and they are refilled in round-robin order. Once all entries are full, each refill replaces the entry that was filled earliest.
- R10: `req_ready` is low while `sw_we` is high, and also while a table read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_va | input | VA_W | Virtual word address |
| req_wr | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_pa | output | PA_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | Page not present |
| rsp_tlb_hit | output | 1 | Response came from the buffer |
| sw_we | input | 1 | Page-table load strobe |
| sw_page | input | VA_W-OFF_W | Page number to load |
| sw_frame | input | PA_W-OFF_W | Frame number to store |
| sw_resident | input | 1 | Present flag to store |
| sw_dirty | input | 1 | Modified flag to store |
| sw_rd_page | input | VA_W-OFF_W | Page number to read back |
| sw_rd_frame | output | PA_W-OFF_W | Frame number of that page |
| sw_rd_resident | output | 1 | Present flag of that page |
| sw_rd_dirty | output | 1 | Modified flag of that page |

## Verification
Some properties are checked by assertions on every cycle. A fault response never carries an address. The returned offset matches the offset of the accepted request. Hits answer after one cycle, and misses stall the request side for a cycle. Software writes hold off new requests. No two buffer entries ever match the same lookup. Other behaviours can only be shown by the bench's scenarios: the frame value that is returned, the round-robin order of eviction, the dropping of a buffer entry after a rewrite, and the modified flags read back after mixed read, write and fault traffic.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int unsigned DEF_VA_W  = 13;
    localparam int unsigned DEF_PA_W  = 12;
    localparam int unsigned DEF_OFF_W = 10;
    localparam int unsigned DEF_TLB_N = 4;

    typedef enum logic {
        ST_LOOK = 1'b0,
        ST_WALK = 1'b1
    } xlt_state_e;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/xlt_pgtab.sv
module xlt_pgtab #(
    parameter int unsigned PN_W = 3,
    parameter int unsigned FN_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PN_W-1:0] rd_page,
    output logic [FN_W-1:0] rd_frame,
    output logic            rd_res,
    input  logic            sw_we,
    input  logic [PN_W-1:0] sw_page,
    input  logic [FN_W-1:0] sw_frame,
    input  logic            sw_res,
    input  logic            sw_dirty,
    input  logic [PN_W-1:0] sw_rd_page,
    output logic [FN_W-1:0] sw_rd_frame,
    output logic            sw_rd_res,
    output logic            sw_rd_dirty,
    input  logic            mark_en,
    input  logic [PN_W-1:0] mark_page
);
    localparam int unsigned NPAGE = 1 << PN_W;

    typedef struct packed {
        logic [FN_W-1:0] frame;
        logic            res;
        logic            dirty;
    } pte_t;

    pte_t tab_q [NPAGE];

    for (genvar p = 0; p < NPAGE; p++) begin : g_pte
        always_ff @(posedge clk) begin
            if (rst) begin
                tab_q[p] <= '0;
            end else if (sw_we && sw_page == PN_W'(p)) begin
                tab_q[p] <= '{frame: sw_frame, res: sw_res, dirty: sw_dirty};
            end else if (mark_en && mark_page == PN_W'(p)) begin
                tab_q[p].dirty <= 1'b1;
            end
        end
    end

    // walk port forwards a same-cycle software load
    always_comb begin
        if (sw_we && sw_page == rd_page) begin
            rd_frame = sw_frame;
            rd_res   = sw_res;
        end else begin
            rd_frame = tab_q[rd_page].frame;
            rd_res   = tab_q[rd_page].res;
        end
    end

    assign sw_rd_frame = tab_q[sw_rd_page].frame;
    assign sw_rd_res   = tab_q[sw_rd_page].res;
    assign sw_rd_dirty = tab_q[sw_rd_page].dirty;
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
    parameter int unsigned PN_W  = 3,
    parameter int unsigned FN_W  = 2,
    parameter int unsigned TLB_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PN_W-1:0]  lk_vpn,
    output logic             hit,
    output logic [FN_W-1:0]  hit_fn,
    output logic [TLB_N-1:0] hit_vec,
    input  logic             fill_en,
    input  logic [PN_W-1:0]  fill_vpn,
    input  logic [FN_W-1:0]  fill_fn,
    input  logic             inv_en,
    input  logic [PN_W-1:0]  inv_vpn
);
    import xlt_pkg::*;
    localparam int unsigned IW = idx_w(TLB_N);

    typedef struct packed {
        logic            vld;
        logic [PN_W-1:0] vpn;
        logic [FN_W-1:0] fn;
    } tlbe_t;

    tlbe_t          ent_q [TLB_N];
    logic [IW-1:0]  ptr_q;

    for (genvar i = 0; i < TLB_N; i++) begin : g_ent
        assign hit_vec[i] = ent_q[i].vld && (ent_q[i].vpn == lk_vpn);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (fill_en && ptr_q == IW'(i)) begin
                ent_q[i] <= '{vld: 1'b1, vpn: fill_vpn, fn: fill_fn};
            end else if (inv_en && ent_q[i].vpn == inv_vpn) begin
                ent_q[i].vld <= 1'b0;
            end
        end
    end

    always_comb begin
        hit_fn = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (hit_vec[i]) hit_fn = hit_fn | ent_q[i].fn;
        end
    end

    assign hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill_en) begin
            ptr_q <= (ptr_q == IW'(TLB_N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl #(
    parameter int unsigned VA_W  = 13,
    parameter int unsigned PA_W  = 12,
    parameter int unsigned OFF_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_va,
    input  logic                   req_wr,
    input  logic                   sw_we,
    output logic [VA_W-OFF_W-1:0]  look_vpn,
    input  logic                   tlb_hit,
    input  logic [PA_W-OFF_W-1:0]  tlb_fn,
    output logic [VA_W-OFF_W-1:0]  pt_page,
    input  logic [PA_W-OFF_W-1:0]  pt_frame,
    input  logic                   pt_res,
    output logic                   fill_en,
    output logic [VA_W-OFF_W-1:0]  fill_vpn,
    output logic [PA_W-OFF_W-1:0]  fill_fn,
    output logic                   mark_en,
    output logic [VA_W-OFF_W-1:0]  mark_page,
    output logic                   rsp_valid,
    output logic [PA_W-1:0]        rsp_pa,
    output logic                   rsp_fault,
    output logic                   rsp_tlb_hit
);
    import xlt_pkg::*;

    xlt_state_e      st_q;
    logic [VA_W-1:0] hold_va_q;
    logic            hold_wr_q;
    logic            accept;
    logic            walking;

    assign walking   = (st_q == ST_WALK);
    assign req_ready = !walking && !sw_we;
    assign accept    = req_valid && req_ready;
    assign look_vpn  = req_va[VA_W-1:OFF_W];
    assign pt_page   = hold_va_q[VA_W-1:OFF_W];

    assign fill_en   = walking && pt_res;
    assign fill_vpn  = pt_page;
    assign fill_fn   = pt_frame;

    assign mark_en   = (accept && tlb_hit && req_wr) || (walking && pt_res && hold_wr_q);
    assign mark_page = walking ? pt_page : look_vpn;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_LOOK;
            hold_va_q   <= '0;
            hold_wr_q   <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_pa      <= '0;
            rsp_fault   <= 1'b0;
            rsp_tlb_hit <= 1'b0;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_tlb_hit <= 1'b0;
            if (walking) begin
                st_q      <= ST_LOOK;
                rsp_valid <= 1'b1;
                if (pt_res) begin
                    rsp_pa <= {pt_frame, hold_va_q[OFF_W-1:0]};
                end else begin
                    rsp_pa    <= '0;
                    rsp_fault <= 1'b1;
                end
            end else if (accept) begin
                if (tlb_hit) begin
                    rsp_valid   <= 1'b1;
                    rsp_tlb_hit <= 1'b1;
                    rsp_pa      <= {tlb_fn, req_va[OFF_W-1:0]};
                end else begin
                    st_q      <= ST_WALK;
                    hold_va_q <= req_va;
                    hold_wr_q <= req_wr;
                end
            end
        end
    end
endmodule

// File: rtl/vmem_xlate.sv
module vmem_xlate #(
    parameter int unsigned VA_W  = xlt_pkg::DEF_VA_W,
    parameter int unsigned PA_W  = xlt_pkg::DEF_PA_W,
    parameter int unsigned OFF_W = xlt_pkg::DEF_OFF_W,
    parameter int unsigned TLB_N = xlt_pkg::DEF_TLB_N
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_wr,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_pa,
    output logic                  rsp_fault,
    output logic                  rsp_tlb_hit,
    input  logic                  sw_we,
    input  logic [VA_W-OFF_W-1:0] sw_page,
    input  logic [PA_W-OFF_W-1:0] sw_frame,
    input  logic                  sw_resident,
    input  logic                  sw_dirty,
    input  logic [VA_W-OFF_W-1:0] sw_rd_page,
    output logic [PA_W-OFF_W-1:0] sw_rd_frame,
    output logic                  sw_rd_resident,
    output logic                  sw_rd_dirty
);
    localparam int unsigned PN_W = VA_W - OFF_W;
    localparam int unsigned FN_W = PA_W - OFF_W;

    logic [PN_W-1:0]  look_vpn, pt_page, fill_vpn, mark_page;
    logic [FN_W-1:0]  tlb_fn, pt_frame, fill_fn;
    logic             tlb_hit, pt_res, fill_en, mark_en;
    logic [TLB_N-1:0] tlb_hit_vec;

    xlt_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_wr(req_wr), .sw_we(sw_we),
        .look_vpn(look_vpn), .tlb_hit(tlb_hit), .tlb_fn(tlb_fn),
        .pt_page(pt_page), .pt_frame(pt_frame), .pt_res(pt_res),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_fn(fill_fn),
        .mark_en(mark_en), .mark_page(mark_page),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_tlb_hit(rsp_tlb_hit)
    );

    xlt_tlb #(.PN_W(PN_W), .FN_W(FN_W), .TLB_N(TLB_N)) u_tlb (
        .clk(clk), .rst(rst),
        .lk_vpn(look_vpn), .hit(tlb_hit), .hit_fn(tlb_fn), .hit_vec(tlb_hit_vec),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_fn(fill_fn),
        .inv_en(sw_we), .inv_vpn(sw_page)
    );

    xlt_pgtab #(.PN_W(PN_W), .FN_W(FN_W)) u_pgtab (
        .clk(clk), .rst(rst),
        .rd_page(pt_page), .rd_frame(pt_frame), .rd_res(pt_res),
        .sw_we(sw_we), .sw_page(sw_page), .sw_frame(sw_frame),
        .sw_res(sw_resident), .sw_dirty(sw_dirty),
        .sw_rd_page(sw_rd_page), .sw_rd_frame(sw_rd_frame),
        .sw_rd_res(sw_rd_resident), .sw_rd_dirty(sw_rd_dirty),
        .mark_en(mark_en), .mark_page(mark_page)
    );
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
    parameter int unsigned VA_W  = 13,
    parameter int unsigned PA_W  = 12,
    parameter int unsigned OFF_W = 10,
    parameter int unsigned TLB_N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_va,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             rsp_fault,
    input logic             rsp_tlb_hit,
    input logic             sw_we,
    input logic [TLB_N-1:0] hit_vec
);
    logic [OFF_W-1:0] acc_off_q;

    always_ff @(posedge clk) begin
        if (rst) acc_off_q <= '0;
        else if (req_valid && req_ready) acc_off_q <= req_va[OFF_W-1:0];
    end

    assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_pa == '0 && !rsp_tlb_hit));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == acc_off_q));

    assert_hit_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (|hit_vec)) |=> (rsp_valid && rsp_tlb_hit));

    assert_miss_stalls_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(|hit_vec)) |=> (!rsp_valid && !req_ready));

    assert_single_match_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_sw_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        sw_we |-> !req_ready);
endmodule

bind vmem_xlate xlt_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .TLB_N(TLB_N)
) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_tlb_hit(rsp_tlb_hit), .sw_we(sw_we), .hit_vec(tlb_hit_vec)
);

// File: tb/tb_vmem_xlate.sv
`timescale 1ns/1ps
module tb_vmem_xlate;
    localparam int VA_W = 13, PA_W = 12, OFF_W = 10, PN_W = 3, FN_W = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_wr = 1'b0;
    logic [VA_W-1:0] req_va = '0;
    logic req_ready, rsp_valid, rsp_fault, rsp_tlb_hit;
    logic [PA_W-1:0] rsp_pa;
    logic sw_we = 1'b0, sw_resident = 1'b0, sw_dirty = 1'b0;
    logic [PN_W-1:0] sw_page = '0, sw_rd_page = '0;
    logic [FN_W-1:0] sw_frame = '0, sw_rd_frame;
    logic sw_rd_resident, sw_rd_dirty;

    always #2.5 clk = ~clk;

    vmem_xlate dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_wr(req_wr), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_tlb_hit(rsp_tlb_hit), .sw_we(sw_we),
        .sw_page(sw_page), .sw_frame(sw_frame), .sw_resident(sw_resident),
        .sw_dirty(sw_dirty), .sw_rd_page(sw_rd_page), .sw_rd_frame(sw_rd_frame),
        .sw_rd_resident(sw_rd_resident), .sw_rd_dirty(sw_rd_dirty)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    // bench-side page-table model
    int m_frm [8];
    bit m_res [8];
    bit m_dty [8];

    // scoreboard queues
    int    q_pa  [$];
    bit    q_flt [$];
    bit    q_hit [$];
    int    q_due [$];
    string q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pops expected responses and compares
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (q_pa.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected response pa=%0h expected none", rsp_pa);
            end else begin
                int epa, edue; bit eflt, ehit; string t;
                epa = q_pa.pop_front(); eflt = q_flt.pop_front();
                ehit = q_hit.pop_front(); edue = q_due.pop_front(); t = q_tag.pop_front();
                if (rsp_pa != PA_W'(epa) || rsp_fault != eflt || rsp_tlb_hit != ehit || cyc != edue) begin
                    errors++;
                    $display("FAIL %s pa=%0h flt=%0b hit=%0b cyc=%0d expected pa=%0h flt=%0b hit=%0b cyc=%0d",
                             t, rsp_pa, rsp_fault, rsp_tlb_hit, cyc, epa, eflt, ehit, edue);
                end
            end
        end
        if (cyc > 5000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog R4 cyc=%0d expected below 5000", cyc);
            report();
        end
    end

    task automatic issue(input int pg, input int off, input bit wr, input bit ehit, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_wr = wr;
        req_va = VA_W'((pg << OFF_W) | off);
        q_flt.push_back(!m_res[pg]);
        q_pa.push_back(m_res[pg] ? ((m_frm[pg] << OFF_W) | off) : 0);
        q_hit.push_back(ehit);
        q_due.push_back(cyc + (ehit ? 1 : 2));
        q_tag.push_back(tag);
        if (wr && m_res[pg]) m_dty[pg] = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b0;
    endtask

    task automatic drain();
        while (q_pa.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_entry(input int pg, input string tag);
        sw_rd_page = PN_W'(pg);
        #0.5;
        checks++;
        if (sw_rd_resident != m_res[pg] || sw_rd_dirty != m_dty[pg] ||
            (m_res[pg] && sw_rd_frame != FN_W'(m_frm[pg]))) begin
            errors++;
            $display("FAIL %s page %0d res=%0b dty=%0b frm=%0d expected res=%0b dty=%0b frm=%0d",
                     tag, pg, sw_rd_resident, sw_rd_dirty, sw_rd_frame, m_res[pg], m_dty[pg], m_frm[pg]);
        end
    endtask

    task automatic sw_load(input int pg, input int frm, input bit res, input bit dty);
        @(negedge clk);
        sw_we = 1'b1; sw_page = PN_W'(pg); sw_frame = FN_W'(frm);
        sw_resident = res; sw_dirty = dty;
        #0.5;
        checks++;
        if (req_ready !== 1'b0) begin
            errors++;
            $display("FAIL R10 req_ready=%0b during load expected 0", req_ready);
        end
        @(negedge clk);
        sw_we = 1'b0;
        m_frm[pg] = frm; m_res[pg] = res; m_dty[pg] = dty;
        check_entry(pg, "R7");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_frm[i] = 0; m_res[i] = 0; m_dty[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 rsp_valid=%0b req_ready=%0b expected 0 1", rsp_valid, req_ready);
        end
        check_entry(5, "R1");
        check_entry(0, "R1");

        // reference configuration: pages 0,3,4,7 in frames 2,0,1,3
        sw_load(0, 2, 1, 0);
        sw_load(3, 0, 1, 0);
        sw_load(4, 1, 1, 0);
        sw_load(7, 3, 1, 0);

        issue(0, 'h155, 0, 0, "R2 R4 miss");       // fills slot 0
        issue(0, 'h3FF, 0, 1, "R2 R3 hit");
        issue(3, 'h000, 1, 0, "R4 R6 write miss"); // slot 1
        issue(4, 'h2A1, 0, 0, "R4 miss");          // slot 2
        issue(7, 'h001, 0, 0, "R4 miss");          // slot 3
        issue(5, 'h123, 1, 0, "R5 fault");
        issue(5, 'h124, 0, 0, "R5 refault no fill");
        issue(7, 'h3FE, 0, 1, "R3 hit");
        issue(3, 'h010, 1, 1, "R3 R6 write hit");
        drain();

        // round-robin replacement
        sw_load(1, 2, 1, 0);
        issue(1, 'h077, 0, 0, "R9 miss evicts slot0");
        issue(4, 'h005, 0, 1, "R9 page4 still held");
        issue(0, 'h006, 0, 0, "R9 page0 evicted");  // slot 1, drops page 3
        issue(3, 'h007, 0, 0, "R9 page3 evicted");  // slot 2, drops page 4
        issue(7, 'h008, 0, 1, "R9 page7 still held");
        drain();

        // rewrite removes buffered translation
        sw_load(7, 0, 1, 0);
        issue(7, 'h100, 0, 0, "R8 miss after rewrite");
        issue(7, 'h101, 0, 1, "R8 hit new frame");
        drain();
        sw_load(1, 2, 0, 0);
        issue(1, 'h077, 0, 0, "R8 R5 cleared page faults");
        drain();

        // modified flags
        check_entry(3, "R6");
        check_entry(4, "R6");
        check_entry(5, "R6");
        check_entry(0, "R6");
        sw_load(6, 1, 0, 1);
        sw_load(3, 0, 1, 0);
        check_entry(3, "R7");

        done = 1'b1;
        repeat (3) @(negedge clk);
        report();
    end
endmodule